// File: doc/BRIEF.md
# Adaptive Buffer-Fill Clock Recovery Loop

This block recovers a line clock from how full a reassembly buffer is. It tracks the buffer's byte count from write and read strobes. It then steers a numerically controlled oscillator so that the count settles at a programmed target fill. A buffer that runs fuller than the target speeds the recovered clock up. A buffer that runs emptier slows it down.

After reset, and after each restart pulse, the loop first runs free for a programmed number of data periods. The correction is held at zero during this time so the buffer can pre-fill. The free-run length is set in units of eight data ticks. Its field is two bits wider than a typical initial-fill setting, so the pre-fill time can be made longer than strictly needed. Once the free-run ends, a proportional-integral controller runs on every data tick. The damping setting picks the loop gains. Both the integrator and the output correction are clamped to a programmed maximum deviation. A lock flag reports that the fill error has stayed small for a long run of updates.

Top module: `fill_clk_recovery`

## Requirements
- R1: The internal fill count starts at 0 and steps up by one on a write strobe and down by one on a read strobe. It does not change when both strobes, or neither, are asserted. It saturates at 0 and at 2^FILL_W-1 (1023 by default) and never wraps.
- R2: Reset (rst_n low at a clock edge) and a restart pulse each clear the fill count, the integrator, `corr`, `out_en`, the oscillator accumulator and `locked`. Both also re-enter the free-run phase. All of these take effect at the clock edge where reset or restart is seen.
- R3: Free-run ends at the data tick that completes 8×`cfg_free_time` ticks; when `cfg_free_time` is 0 it ends at the first tick. `corr` reads 0 during the whole free-run phase. Tracking then continues until the next restart or reset.
- R4: On each data tick in the tracking phase, the error is e = fill − `cfg_target`. The integrator becomes I' = clamp(I + (e >>> (`cfg_damp`+3))). `corr` becomes clamp(I' + (e >>> `cfg_damp`)). Both shifts are arithmetic right shifts.
- R5: The clamp bound is ±`cfg_max_dev`. `corr` never exceeds it in magnitude.
- R6: On every clock, the accumulator adds NOM_INC + `corr` modulo 2^ACC_W. `out_en` is the carry out of that sum, registered. With the default NOM_INC of 0x4000 and `corr` at 0, this gives exactly one pulse every 4 clocks.
- R7: `locked` is set on the tick where LOCK_N (256) consecutive tracking updates have all had |e| ≤ LOCK_WIN (2). Any tracking update with |e| > LOCK_WIN clears both `locked` and the run count.
- R8: In the tracking phase, `corr` holds its value on clocks without a data tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Restart pulse: clears the loop and re-enters free-run |
| data_tick | input | 1 | One data-period tick (clock enable) |
| wr_stb | input | 1 | One byte written into the buffer |
| rd_stb | input | 1 | One byte read from the buffer |
| cfg_target | input | FILL_W | Target average fill in bytes |
| cfg_free_time | input | INIT_W+2 | Free-run length in units of 8 data ticks |
| cfg_damp | input | 2 | Damping select (gain shifts) |
| cfg_max_dev | input | CORR_W-1 | Magnitude bound of the frequency correction |
| out_en | output | 1 | Recovered clock enable pulse |
| corr | output | CORR_W | Signed frequency correction |
| locked | output | 1 | Fill error has stayed inside the window |

## Verification
The assertions check several rules on every clock. The fill count never moves by more than one byte at a time. A restart leaves every loop state cleared on the next clock. The correction is zero throughout free-run and stays within the programmed bound. The lock flag is only seen in the tracking phase, and the correction only changes on a data tick. Other behaviour needs the bench's scenarios, which compare against a behavioural model on every clock. These cover the exact arithmetic of the controller gains and saturation, the exact tick on which free-run ends, the oscillator pulse rate, and the 256-update lock run with its loss on an excursion. Saturation of the fill count at both ends is visible only through its effect on the correction.

// File: rtl/bfr_pkg.sv
// Package: shared phase type and damping-to-shift mapping for the
// buffer-fill clock recovery loop. Assumes two damping select bits.
package bfr_pkg;

    typedef enum logic {
        PH_FREE  = 1'b0,
        PH_TRACK = 1'b1
    } phase_e;

    // Extra right shift of the integral path over the proportional path.
    localparam int KI_EXTRA = 3;

    // Proportional gain shift chosen by the damping select.
    function automatic logic [2:0] kp_shift(input logic [1:0] damp);
        return {1'b0, damp};
    endfunction

    // Integral gain shift chosen by the damping select.
    function automatic logic [2:0] ki_shift(input logic [1:0] damp);
        return {1'b0, damp} + 3'(KI_EXTRA);
    endfunction

endpackage

// File: rtl/bfr_fill_cnt.sv
// Module: saturating byte counter that mirrors the reassembly buffer fill.
// Assumes at most one write and one read strobe per clock.
module bfr_fill_cnt #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         wr,
    input  logic         rd,
    output logic [W-1:0] fill
);

    // Step the count by the net strobe, holding at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            fill <= '0;
        end else if (wr && !rd && fill != '1) begin
            fill <= fill + 1'b1;
        end else if (rd && !wr && fill != '0) begin
            fill <= fill - 1'b1;
        end
    end

endmodule

// File: rtl/bfr_run_ctl.sv
// Module: free-run timer. Holds the loop in the free phase for 8*T data
// ticks after reset or restart, then hands over to tracking.
// Assumes T < 2^TW; a T of zero ends free-run on the first tick.
module bfr_run_ctl
    import bfr_pkg::*;
#(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          tick,
    input  logic [TW-1:0] free_time,
    output phase_e        phase
);

    localparam int CW = TW + 3;

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_inc;
    logic [CW-1:0] limit;

    // Tick budget and next count value.
    always_comb begin
        limit   = {free_time, 3'b000};
        cnt_inc = cnt + 1'b1;
    end

    // Count ticks while free; switch to tracking when the budget is met.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            phase <= PH_FREE;
            cnt   <= '0;
        end else if (tick && phase == PH_FREE) begin
            cnt <= cnt_inc;
            if (cnt_inc >= limit) begin
                phase <= PH_TRACK;
            end
        end
    end

endmodule

// File: rtl/bfr_pi_ctl.sv
// Module: proportional-integral controller on the fill error, plus the
// lock detector. Updates once per data tick while tracking.
// Assumes FW+1 <= CW+2 so the error fits the internal sum width.
module bfr_pi_ctl
    import bfr_pkg::*;
#(
    parameter int FW     = 10,
    parameter int CW     = 12,
    parameter int WIN    = 2,
    parameter int LOCK_N = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic                 tick,
    input  logic                 track,
    input  logic [FW-1:0]        fill,
    input  logic [FW-1:0]        target,
    input  logic [1:0]           damp,
    input  logic [CW-2:0]        max_dev,
    output logic signed [CW-1:0] corr,
    output logic                 locked
);

    localparam int EW  = FW + 1;
    localparam int SW  = CW + 2;
    localparam int LCW = $clog2(LOCK_N);

    logic signed [EW-1:0]  err, err_i, err_p, mag;
    logic signed [SW-1:0]  lim, nlim, isum, csum;
    logic signed [CW-1:0]  integ, integ_nx, corr_nx;
    logic                  in_win;
    logic [LCW-1:0]        lcnt;

    // Saturate a wide value to the symmetric bound.
    function automatic logic signed [CW-1:0] clip(
        input logic signed [SW-1:0] v,
        input logic signed [SW-1:0] hi,
        input logic signed [SW-1:0] lo
    );
        if (v > hi)      return CW'(hi);
        else if (v < lo) return CW'(lo);
        else             return CW'(v);
    endfunction

    // Error, gain shifts, integrator and output candidates.
    always_comb begin
        err      = $signed({1'b0, fill}) - $signed({1'b0, target});
        err_i    = err >>> ki_shift(damp);
        err_p    = err >>> kp_shift(damp);
        lim      = $signed({3'b000, max_dev});
        nlim     = -lim;
        isum     = SW'(integ) + SW'(err_i);
        integ_nx = clip(isum, lim, nlim);
        csum     = SW'(integ_nx) + SW'(err_p);
        corr_nx  = clip(csum, lim, nlim);
        mag      = err[EW-1] ? -err : err;
        in_win   = mag <= $signed(EW'(WIN));
    end

    // Controller state: cleared while free, advanced on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !track) begin
            integ <= '0;
            corr  <= '0;
        end else if (tick) begin
            integ <= integ_nx;
            corr  <= corr_nx;
        end
    end

    // Lock detector: run of in-window updates, broken by any excursion.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            lcnt   <= '0;
            locked <= 1'b0;
        end else if (track && tick) begin
            if (!in_win) begin
                lcnt   <= '0;
                locked <= 1'b0;
            end else if (lcnt == LCW'(LOCK_N - 1)) begin
                locked <= 1'b1;
            end else begin
                lcnt <= lcnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bfr_nco.sv
// Module: phase accumulator oscillator. Adds nominal increment plus the
// signed correction each clock; the carry is the clock enable.
// Assumes NOM_INC + |corr| < 2^AW and NOM_INC > |corr|.
module bfr_nco #(
    parameter int            AW      = 16,
    parameter int            CW      = 12,
    parameter logic [AW-1:0] NOM_INC = 16'h4000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 restart,
    input  logic signed [CW-1:0] corr,
    output logic                 out_en
);

    logic [AW-1:0] acc;
    logic [AW:0]   inc, sum;

    // Corrected increment and accumulator sum with carry.
    always_comb begin
        inc = {1'b0, NOM_INC} + (AW + 1)'(corr);
        sum = {1'b0, acc} + inc;
    end

    // Advance the phase and register the carry as the enable.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            acc    <= '0;
            out_en <= 1'b0;
        end else begin
            acc    <= sum[AW-1:0];
            out_en <= sum[AW];
        end
    end

endmodule

// File: rtl/fill_clk_recovery.sv
// Module: top of the buffer-fill clock recovery loop. Ties the fill
// counter, free-run timer, PI controller and oscillator together.
// Assumes all inputs are synchronous to clk.
module fill_clk_recovery
    import bfr_pkg::*;
#(
    parameter int              FILL_W   = 10,
    parameter int              INIT_W   = 6,
    parameter int              CORR_W   = 12,
    parameter int              ACC_W    = 16,
    parameter logic [ACC_W-1:0] NOM_INC = 16'h4000,
    parameter int              LOCK_WIN = 2,
    parameter int              LOCK_N   = 256
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     restart,
    input  logic                     data_tick,
    input  logic                     wr_stb,
    input  logic                     rd_stb,
    input  logic [FILL_W-1:0]        cfg_target,
    input  logic [INIT_W+1:0]        cfg_free_time,
    input  logic [1:0]               cfg_damp,
    input  logic [CORR_W-2:0]        cfg_max_dev,
    output logic                     out_en,
    output logic signed [CORR_W-1:0] corr,
    output logic                     locked
);

    localparam int TIME_W = INIT_W + 2;

    logic [FILL_W-1:0] fill_q;
    phase_e            phase_q;
    logic              track;

    // Tracking qualifier for the controller.
    always_comb track = (phase_q == PH_TRACK);

    bfr_fill_cnt #(.W(FILL_W)) u_fill (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (restart),
        .wr   (wr_stb),
        .rd   (rd_stb),
        .fill (fill_q)
    );

    bfr_run_ctl #(.TW(TIME_W)) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .tick     (data_tick),
        .free_time(cfg_free_time),
        .phase    (phase_q)
    );

    bfr_pi_ctl #(
        .FW    (FILL_W),
        .CW    (CORR_W),
        .WIN   (LOCK_WIN),
        .LOCK_N(LOCK_N)
    ) u_pi (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .tick   (data_tick),
        .track  (track),
        .fill   (fill_q),
        .target (cfg_target),
        .damp   (cfg_damp),
        .max_dev(cfg_max_dev),
        .corr   (corr),
        .locked (locked)
    );

    bfr_nco #(
        .AW     (ACC_W),
        .CW     (CORR_W),
        .NOM_INC(NOM_INC)
    ) u_nco (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(restart),
        .corr   (corr),
        .out_en (out_en)
    );

endmodule

// File: rtl/bfr_checker.sv
// Module: assertion checker bound to fill_clk_recovery. Observes ports
// and the fill and phase state; drives nothing.
module bfr_checker
    import bfr_pkg::*;
#(
    parameter int FILL_W = 10,
    parameter int CORR_W = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     restart,
    input logic                     data_tick,
    input logic [CORR_W-2:0]        cfg_max_dev,
    input logic [FILL_W-1:0]        fill_q,
    input phase_e                   phase_q,
    input logic signed [CORR_W-1:0] corr,
    input logic                     locked,
    input logic                     out_en
);

    // R1: fill moves by at most one byte per clock and never wraps
    a_r1_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(restart) |->
            ({1'b0, fill_q} == {1'b0, $past(fill_q)} ||
             {1'b0, fill_q} == {1'b0, $past(fill_q)} + 1'b1 ||
             {1'b0, fill_q} + 1'b1 == {1'b0, $past(fill_q)}));

    // R2: restart clears the whole loop state on the next clock
    a_r2_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (fill_q == '0 && phase_q == PH_FREE && !locked &&
                     corr == '0 && !out_en));

    // R3: no correction during free-run
    a_r3_free_no_corr: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_FREE |-> corr == '0);

    // R3: tracking persists until restart
    a_r3_track_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_TRACK && !restart) |=> phase_q == PH_TRACK);

    // R5: correction stays within the programmed bound
    a_r5_corr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cfg_max_dev) |->
            (corr <= $signed({1'b0, cfg_max_dev}) &&
             corr >= -$signed({1'b0, cfg_max_dev})));

    // R7: lock is only reported while tracking
    a_r7_lock_in_track: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> phase_q == PH_TRACK);

    // R8: correction changes only on a data tick
    a_r8_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_TRACK && !data_tick && !restart) |=> $stable(corr));

endmodule

bind fill_clk_recovery bfr_checker #(
    .FILL_W(FILL_W),
    .CORR_W(CORR_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart),
    .data_tick  (data_tick),
    .cfg_max_dev(cfg_max_dev),
    .fill_q     (fill_q),
    .phase_q    (phase_q),
    .corr       (corr),
    .locked     (locked),
    .out_en     (out_en)
);

// File: tb/fill_clk_recovery_tb_top.sv
module fill_clk_recovery_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NOM        = 16384;
    localparam int ACC_MOD    = 65536;
    localparam int FILL_MAX   = 1023;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               restart = 1'b0;
    logic               data_tick = 1'b0;
    logic               wr_stb = 1'b0;
    logic               rd_stb = 1'b0;
    logic [9:0]         cfg_target = '0;
    logic [7:0]         cfg_free_time = '0;
    logic [1:0]         cfg_damp = '0;
    logic [10:0]        cfg_max_dev = '0;
    logic               out_en;
    logic signed [11:0] corr;
    logic               locked;

    int n_chk = 0;
    int n_fail = 0;
    string tag = "R4";
    bit cmp_en = 0;

    // behavioural model state
    int m_fill, m_tcnt, m_integ, m_corr, m_lcnt, m_acc;
    bit m_free, m_locked, m_out;
    int div = 0;

    fill_clk_recovery dut_i (
        .clk(clk), .rst_n(rst_n), .restart(restart), .data_tick(data_tick),
        .wr_stb(wr_stb), .rd_stb(rd_stb), .cfg_target(cfg_target),
        .cfg_free_time(cfg_free_time), .cfg_damp(cfg_damp),
        .cfg_max_dev(cfg_max_dev), .out_en(out_en), .corr(corr), .locked(locked)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int clampi(input int v, input int m);
        if (v > m) return m;
        if (v < -m) return -m;
        return v;
    endfunction

    task automatic model_clear();
        m_fill = 0; m_tcnt = 0; m_integ = 0; m_corr = 0; m_lcnt = 0;
        m_acc = 0; m_free = 1; m_locked = 0; m_out = 0;
    endtask

    initial model_clear();

    // data tick every fourth clock
    always @(negedge clk) begin
        if (!rst_n) begin
            div = 0;
            data_tick = 0;
        end else begin
            div = (div + 1) % 4;
            data_tick = (div == 0);
        end
    end

    // reference model, advanced at each rising edge from the inputs
    always @(posedge clk) begin
        int s, e, mx, ab;
        cmp_en = 1;
        if (!rst_n || restart) begin
            model_clear();
        end else begin
            s = m_acc + NOM + m_corr;
            m_out = (s >= ACC_MOD);
            m_acc = s % ACC_MOD;
            mx = int'(cfg_max_dev);
            if (m_free) begin
                m_integ = 0; m_corr = 0;
                if (data_tick) begin
                    m_tcnt++;
                    if (m_tcnt >= 8 * int'(cfg_free_time)) m_free = 0;
                end
            end else if (data_tick) begin
                e = m_fill - int'(cfg_target);
                m_integ = clampi(m_integ + (e >>> (int'(cfg_damp) + 3)), mx);
                m_corr  = clampi(m_integ + (e >>> int'(cfg_damp)), mx);
                ab = (e < 0) ? -e : e;
                if (ab > 2) begin
                    m_lcnt = 0; m_locked = 0;
                end else if (m_lcnt == 255) begin
                    m_locked = 1;
                end else begin
                    m_lcnt++;
                end
            end
            if (wr_stb && !rd_stb && m_fill < FILL_MAX) m_fill++;
            else if (rd_stb && !wr_stb && m_fill > 0) m_fill--;
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(int'(corr) == m_corr, tag, int'(corr), m_corr);
            chk(out_en == m_out, "R6", int'(out_en), int'(m_out));
            chk(locked == m_locked, "R7", int'(locked), int'(m_locked));
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input bit w, input bit r, input int n);
        @(negedge clk);
        wr_stb = w; rd_stb = r;
        cycles(n);
        wr_stb = 0; rd_stb = 0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
        $finish;
    end

    initial begin
        int pulses, c1, c2;
        cfg_target = 10'd40; cfg_free_time = 8'd2; cfg_damp = 2'd1; cfg_max_dev = 11'd20;
        cycles(3);
        // R2: reset state
        chk(corr == 0 && !locked && !out_en, "R2", int'(corr), 0);
        tag = "R3";
        @(negedge clk); rst_n = 1;
        // R6: exactly one enable pulse every 4 clocks with no correction
        pulses = 0;
        wr_stb = 1;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (out_en) pulses++;
        end
        wr_stb = 0;
        chk(pulses == 10, "R6", pulses, 10);
        // R3: still free after 41 clocks (about 10 of 16 ticks)
        chk(corr == 0, "R3", int'(corr), 0);
        cycles(40);
        tag = "R4";
        // fill above target: correction climbs to the bound
        strobe(1, 0, 30);
        cycles(200);
        chk(int'(corr) == 20, "R5", int'(corr), 20);
        // R8: correction holds between ticks
        wait (data_tick);
        @(negedge clk); c1 = int'(corr);
        @(negedge clk); c2 = int'(corr);
        chk(c1 == c2, "R8", c2, c1);
        // return to target and hold for the lock run
        strobe(0, 1, 30);
        cycles(1100);
        chk(locked == 1, "R7", int'(locked), 1);
        strobe(1, 0, 5);
        cycles(8);
        chk(locked == 0, "R7", int'(locked), 0);
        // R1: saturate at empty and at full
        tag = "R1";
        cfg_max_dev = 11'd2000; cfg_damp = 2'd0;
        strobe(0, 1, 100);
        cycles(20);
        chk(int'(corr) < 0, "R1", int'(corr), -1);
        strobe(1, 0, 1100);
        cycles(20);
        chk(int'(corr) > 0, "R1", int'(corr), 1);
        // R2: restart clears, then a zero-length free-run
        tag = "R3";
        @(negedge clk);
        cfg_free_time = 8'd0; cfg_damp = 2'd3; restart = 1;
        @(negedge clk); restart = 0;
        chk(corr == 0 && !locked && !out_en, "R2", int'(corr), 0);
        cycles(8);
        tag = "R4";
        cycles(200);
        chk(int'(corr) < 0, "R4", int'(corr), -1);
        summary();
        $finish;
    end

endmodule